// File: doc/BRIEF.md
# Binary Floating-Point Adder with Exact Special-Value Rules

This block adds two binary floating-point numbers (single precision by default, with exponent and fraction widths as parameters). It produces a correctly rounded sum in any of four rounding modes. Alongside the sum it reports invalid, denormal, overflow and underflow conditions. A status bit shows whether rounding made the result larger in magnitude than the exact sum. The flags are only reported. Nothing traps.

An operand pair and a rounding mode are presented with an input strobe. The result appears on registered outputs one clock later, with an output strobe. Zeros, infinities and NaNs bypass the arithmetic path and are resolved by a fixed rule set. The rule set fixes the sign of an exact zero, the handling of infinities and the choice of the NaN that is returned. Finite operands go through alignment with guard, round and sticky bits, then a single add or subtract, normalisation bounded by the minimum exponent, and rounding.

Top module: `fpadd_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise; results leave in the order operands entered.
- R2: A finite sum is correctly rounded in the selected mode, encoded on `rnd_mode` as 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R3: When the exact sum of two finite operands is zero and their signs differ, the result is +0 in every mode except 01, which gives -0; two zeros of the same sign give that zero.
- R4: A nonzero finite operand added to a zero of either sign returns the nonzero operand bit for bit.
- R5: Two infinities of the same sign give that infinity, and an infinity plus a finite value gives the infinity, with no flag raised.
- R6: Infinities of opposite sign raise `flag_invalid` and return the default NaN 0xFFC00000 (sign 1, exponent all ones, only the top fraction bit set).
- R7: With any NaN operand the result is the first NaN operand (`op_a` before `op_b`) with its top fraction bit forced to 1; `flag_invalid` is raised exactly when an operand is a signalling NaN (top fraction bit clear).
- R8: `flag_denorm` is raised whenever an operand has a zero exponent field and a nonzero fraction.
- R9: When the rounded exponent reaches all ones, `flag_overflow` is raised. The result is infinity in mode 00, in mode 10 for a positive sum and in mode 01 for a negative sum. In every other case it is the largest finite value of the sum's sign.
- R10: `flag_underflow` is raised when a finite nonzero result has a zero exponent field.
- R11: `rounded_up` is high exactly when the returned magnitude exceeds the exact sum's magnitude, which includes overflow to infinity; it is low for exact results, zeros and special-value results.
- R12: After reset `out_valid`, `sum` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_a | input | 32 | First operand (1+EXP_W+MAN_W bits) |
| op_b | input | 32 | Second operand |
| rnd_mode | input | 2 | Rounding mode select |
| out_valid | output | 1 | Registered result is valid |
| sum | output | 32 | Rounded sum |
| flag_invalid | output | 1 | Invalid operation |
| flag_denorm | output | 1 | Denormal operand seen |
| flag_overflow | output | 1 | Result exceeded the largest finite value |
| flag_underflow | output | 1 | Nonzero result below the normal range |
| rounded_up | output | 1 | Rounding increased the magnitude |

## Verification
Rounding and overflow can act on the same result. An increment that carries into the exponent, or a sum whose exponent is already at the top, must set both the overflow and rounded-up bits, or overflow alone, depending on mode and sign. The bench provokes this by adding the largest finite value to itself in all four modes and with both signs. It judges the sum and both status bits against values worked out by hand. The denormal flag can also coincide with underflow or with an upward rounding. The bench covers this with denormal operands whose sums stay tiny, reach the minimum normal, or only perturb a normal operand's sticky bit.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_TO_NEG    = 2'b01,
        RND_TO_POS    = 2'b10,
        RND_TO_ZERO   = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic denorm;
        logic inf;
        logic nan;
        logic snan;
    } op_class_t;

    typedef struct packed {
        logic invalid;
        logic denorm;
        logic overflow;
        logic underflow;
        logic rounded_up;
    } add_flags_t;

    // Decide whether the truncated significand must be bumped by one ulp.
    function automatic logic round_increment(input rnd_mode_e mode, input logic sign,
                                             input logic lsb, input logic grd,
                                             input logic rnd, input logic stk);
        logic inexact;
        inexact = grd | rnd | stk;
        case (mode)
            RND_NEAR_EVEN: return grd & (rnd | stk | lsb);
            RND_TO_NEG:    return sign & inexact;
            RND_TO_POS:    return ~sign & inexact;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op,
    output op_class_t            cls
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    always_comb begin
        expo       = op[EXP_W+MAN_W-1:MAN_W];
        frac       = op[MAN_W-1:0];
        cls.denorm = (expo == '0) && (frac != '0);
        cls.inf    = (expo == '1) && (frac == '0);
        cls.nan    = (expo == '1) && (frac != '0);
        cls.snan   = (expo == '1) && (frac != '0) && !frac[MAN_W-1];
    end
endmodule

// File: rtl/fpadd_special.sv
module fpadd_special
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  op_class_t            cls_a,
    input  op_class_t            cls_b,
    output logic                 take,
    output logic                 invalid,
    output logic [EXP_W+MAN_W:0] result
);
    localparam int TOP = EXP_W + MAN_W;
    localparam logic [TOP:0] QUIET_BIT = (TOP+1)'(1) << (MAN_W - 1);
    localparam logic [TOP:0] DEFAULT_NAN =
        {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    always_comb begin
        take    = 1'b0;
        invalid = 1'b0;
        result  = '0;
        if (cls_a.nan || cls_b.nan) begin
            take    = 1'b1;
            invalid = cls_a.snan | cls_b.snan;
            result  = (cls_a.nan ? op_a : op_b) | QUIET_BIT;
        end else if (cls_a.inf && cls_b.inf && (op_a[TOP] != op_b[TOP])) begin
            take    = 1'b1;
            invalid = 1'b1;
            result  = DEFAULT_NAN;
        end else if (cls_a.inf) begin
            take   = 1'b1;
            result = op_a;
        end else if (cls_b.inf) begin
            take   = 1'b1;
            result = op_b;
        end
    end
endmodule

// File: rtl/fpadd_normal.sv
module fpadd_normal
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  rnd_mode_e            mode,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 ovf,
    output logic                 unf,
    output logic                 rup
);
    localparam int TOP   = EXP_W + MAN_W;
    localparam int SIG_W = MAN_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int SH_W  = $clog2(EXT_W + 1);
    localparam logic [EXP_W-1:0] EXP_TOP = '1;
    localparam logic [EXP_W-1:0] EXP_BIG = EXP_TOP - 1'b1;
    localparam logic [EXP_W:0]   EXP_LIM = {1'b0, EXP_TOP};

    logic             swap, sx, sub, lost, inc, to_inf;
    logic [TOP:0]     x, y;
    logic [EXP_W-1:0] xe, ye, ex, ey, diff;
    logic [SH_W-1:0]  dcl;
    logic [EXT_W-1:0] xext, yext, yal, nrm;
    logic [EXT_W:0]   mag;
    logic [SIG_W:0]   rsig;
    logic [EXP_W:0]   e_pre, e_fin;
    logic [MAN_W-1:0] m_fin;
    int               lz, limit, shamt;

    always_comb begin
        // order operands by magnitude so the subtraction never goes negative
        swap = op_b[TOP-1:0] > op_a[TOP-1:0];
        x    = swap ? op_b : op_a;
        y    = swap ? op_a : op_b;
        sx   = x[TOP];
        sub  = x[TOP] ^ y[TOP];
        xe   = x[TOP-1:MAN_W];
        ye   = y[TOP-1:MAN_W];
        ex   = (xe == '0) ? EXP_W'(1) : xe;
        ey   = (ye == '0) ? EXP_W'(1) : ye;
        diff = ex - ey;
        dcl  = (int'(diff) >= EXT_W) ? SH_W'(EXT_W) : SH_W'(diff);

        // alignment with guard, round and sticky positions
        xext   = {(xe != '0), x[MAN_W-1:0], 3'b000};
        yext   = {(ye != '0), y[MAN_W-1:0], 3'b000};
        yal    = yext >> dcl;
        lost   = |(yext & ~({EXT_W{1'b1}} << dcl));
        yal[0] = yal[0] | lost;
        mag    = sub ? ({1'b0, xext} - {1'b0, yal}) : ({1'b0, xext} + {1'b0, yal});

        // leading-zero count below the carry position
        lz = EXT_W;
        for (int i = 0; i < EXT_W; i++) begin
            if (mag[i]) lz = EXT_W - 1 - i;
        end
        limit = int'(ex) - 1;
        shamt = (lz > limit) ? limit : lz;

        nrm   = '0;
        e_pre = '0;
        if (mag[EXT_W]) begin
            nrm    = mag[EXT_W:1];
            nrm[0] = mag[1] | mag[0];
            e_pre  = {1'b0, ex} + 1'b1;
        end else begin
            nrm   = mag[EXT_W-1:0] << shamt;
            e_pre = {1'b0, ex} - (EXP_W+1)'(shamt);
        end

        inc  = round_increment(mode, sx, nrm[3], nrm[2], nrm[1], nrm[0]);
        rsig = {1'b0, nrm[EXT_W-1:3]} + (SIG_W+1)'(inc);
        if (rsig[SIG_W]) begin
            e_fin = e_pre + 1'b1;
            m_fin = '0;
        end else begin
            e_fin = rsig[SIG_W-1] ? e_pre : '0;
            m_fin = rsig[MAN_W-1:0];
        end

        to_inf = (mode == RND_NEAR_EVEN) || ((mode == RND_TO_POS) && !sx) ||
                 ((mode == RND_TO_NEG) && sx);

        ovf = 1'b0;
        unf = 1'b0;
        rup = 1'b0;
        if (mag == '0) begin
            result = {(sub ? (mode == RND_TO_NEG) : sx), {TOP{1'b0}}};
        end else if (e_fin >= EXP_LIM) begin
            ovf    = 1'b1;
            rup    = to_inf;
            result = to_inf ? {sx, EXP_TOP, {MAN_W{1'b0}}} : {sx, EXP_BIG, {MAN_W{1'b1}}};
        end else begin
            result = {sx, e_fin[EXP_W-1:0], m_fin};
            unf    = (e_fin == '0);
            rup    = inc;
        end
    end
endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [1:0]           rnd_mode,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] sum,
    output logic                 flag_invalid,
    output logic                 flag_denorm,
    output logic                 flag_overflow,
    output logic                 flag_underflow,
    output logic                 rounded_up
);
    localparam int WORD_W = EXP_W + MAN_W + 1;

    op_class_t         cls_a, cls_b;
    logic              sp_take, sp_invalid, nm_ovf, nm_unf, nm_rup;
    logic [WORD_W-1:0] sp_result, nm_result, nxt_sum;
    add_flags_t        nxt_flags;

    fpadd_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_a (.op(op_a), .cls(cls_a));
    fpadd_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls_b (.op(op_b), .cls(cls_b));

    fpadd_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_special (
        .op_a(op_a), .op_b(op_b), .cls_a(cls_a), .cls_b(cls_b),
        .take(sp_take), .invalid(sp_invalid), .result(sp_result)
    );

    fpadd_normal #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_normal (
        .op_a(op_a), .op_b(op_b), .mode(rnd_mode_e'(rnd_mode)),
        .result(nm_result), .ovf(nm_ovf), .unf(nm_unf), .rup(nm_rup)
    );

    always_comb begin
        nxt_flags        = '0;
        nxt_flags.denorm = cls_a.denorm | cls_b.denorm;
        if (sp_take) begin
            nxt_sum           = sp_result;
            nxt_flags.invalid = sp_invalid;
        end else begin
            nxt_sum              = nm_result;
            nxt_flags.overflow   = nm_ovf;
            nxt_flags.underflow  = nm_unf;
            nxt_flags.rounded_up = nm_rup;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            sum            <= '0;
            flag_invalid   <= 1'b0;
            flag_denorm    <= 1'b0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
            rounded_up     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum            <= nxt_sum;
                flag_invalid   <= nxt_flags.invalid;
                flag_denorm    <= nxt_flags.denorm;
                flag_overflow  <= nxt_flags.overflow;
                flag_underflow <= nxt_flags.underflow;
                rounded_up     <= nxt_flags.rounded_up;
            end
        end
    end
endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [EXP_W+MAN_W:0] op_b,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] sum,
    input logic                 flag_invalid,
    input logic                 flag_denorm,
    input logic                 flag_overflow,
    input logic                 flag_underflow,
    input logic                 rounded_up
);
    localparam int TOP = EXP_W + MAN_W;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R6
    invalid_gives_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid) |-> (sum[TOP-1:MAN_W] == '1 && sum[MAN_W-1:0] != '0));
    // R11
    invalid_not_rounded_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid) |-> !rounded_up);
    // R9
    overflow_value_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_overflow) |->
            ((sum[TOP-1:MAN_W] == '1 && sum[MAN_W-1:0] == '0) ||
             (sum[TOP-1:MAN_W] == {{(EXP_W-1){1'b1}}, 1'b0} && sum[MAN_W-1:0] == '1)));
    // R10
    underflow_tiny_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_underflow) |-> (sum[TOP-1:MAN_W] == '0 && sum[MAN_W-1:0] != '0));
    // R8
    denorm_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((op_a[TOP-1:MAN_W] == '0 && op_a[MAN_W-1:0] != '0) ||
                      (op_b[TOP-1:MAN_W] == '0 && op_b[MAN_W-1:0] != '0))) |=> flag_denorm);
    // R5
    same_inf_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_a == op_b && op_a[TOP-1:MAN_W] == '1 && op_a[MAN_W-1:0] == '0)
            |=> (sum == $past(op_a) && !flag_invalid));
endmodule

bind fpadd_unit fpadd_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_fpadd_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .sum(sum), .flag_invalid(flag_invalid),
    .flag_denorm(flag_denorm), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .rounded_up(rounded_up)
);

// File: tb/test_fpadd_unit.sv
`timescale 1ns/1ps
module test_fpadd_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        out_valid, flag_invalid, flag_denorm, flag_overflow, flag_underflow, rounded_up;
    logic [31:0] sum;

    typedef struct {
        logic [31:0] exp_sum;
        logic [4:0]  exp_flags;  // {invalid, denorm, overflow, underflow, rounded_up}
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [1:0] NE = 2'b00, DN = 2'b01, UP = 2'b10, RZ = 2'b11;

    always #2 clk = ~clk;

    fpadd_unit i_fpadd_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .rnd_mode(rnd_mode), .out_valid(out_valid), .sum(sum),
        .flag_invalid(flag_invalid), .flag_denorm(flag_denorm),
        .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
        .rounded_up(rounded_up)
    );

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m,
                         input logic [31:0] es, input logic [4:0] ef, input string req);
        sb_item_t it;
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        rnd_mode = m;
        in_valid = 1'b1;
        it.exp_sum   = es;
        it.exp_flags = ef;
        it.req       = req;
        sb_q.push_back(it);
    endtask

    // monitor: compares each produced result against the queue head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            sb_item_t it;
            logic [4:0] got;
            got = {flag_invalid, flag_denorm, flag_overflow, flag_underflow, rounded_up};
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R1: unexpected result %h flags %b, expected none", sum, got);
            end else begin
                it = sb_q.pop_front();
                if (sum !== it.exp_sum || got !== it.exp_flags) begin
                    errors++;
                    $display("FAIL %s: sum %h flags %b, expected sum %h flags %b",
                             it.req, sum, got, it.exp_sum, it.exp_flags);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        checks++;
        if (out_valid !== 1'b0 || sum !== 32'h0 ||
            {flag_invalid, flag_denorm, flag_overflow, flag_underflow, rounded_up} !== 5'b0) begin
            errors++;
            $display("FAIL R12: valid %b sum %h, expected 0 and 0", out_valid, sum);
        end

        // R2 plain, carry, cancellation, subtraction
        drive(32'h3F800000, 32'h40000000, NE, 32'h40400000, 5'b00000, "R2");
        drive(32'h3FC00000, 32'h3FC00000, NE, 32'h40400000, 5'b00000, "R2");
        drive(32'h3FC00000, 32'hBF800000, NE, 32'h3F000000, 5'b00000, "R2");
        drive(32'h3F800000, 32'hB3800000, NE, 32'h3F7FFFFF, 5'b00000, "R2");
        // R2/R11 half-ulp tie in each mode, tie to odd, above half
        drive(32'h3F800000, 32'h33800000, NE, 32'h3F800000, 5'b00000, "R2");
        drive(32'h3F800000, 32'h33800000, UP, 32'h3F800001, 5'b00001, "R11");
        drive(32'h3F800000, 32'h33800000, RZ, 32'h3F800000, 5'b00000, "R2");
        drive(32'h3F800000, 32'h33800000, DN, 32'h3F800000, 5'b00000, "R2");
        drive(32'h3F800001, 32'h33800000, NE, 32'h3F800002, 5'b00001, "R2");
        drive(32'h3F800000, 32'h33C00000, NE, 32'h3F800001, 5'b00001, "R11");
        drive(32'hBF800000, 32'hB3C00000, DN, 32'hBF800001, 5'b00001, "R11");
        drive(32'hBF800000, 32'hB3C00000, UP, 32'hBF800000, 5'b00000, "R2");
        // R3 exact zeros
        drive(32'h3F800000, 32'hBF800000, NE, 32'h00000000, 5'b00000, "R3");
        drive(32'h3F800000, 32'hBF800000, DN, 32'h80000000, 5'b00000, "R3");
        drive(32'h3F800000, 32'hBF800000, UP, 32'h00000000, 5'b00000, "R3");
        drive(32'h3F800000, 32'hBF800000, RZ, 32'h00000000, 5'b00000, "R3");
        drive(32'h00000000, 32'h80000000, NE, 32'h00000000, 5'b00000, "R3");
        drive(32'h00000000, 32'h80000000, DN, 32'h80000000, 5'b00000, "R3");
        drive(32'h80000000, 32'h80000000, NE, 32'h80000000, 5'b00000, "R3");
        drive(32'h00000000, 32'h00000000, DN, 32'h00000000, 5'b00000, "R3");
        // R4 finite plus zero
        drive(32'h3FC00000, 32'h80000000, DN, 32'h3FC00000, 5'b00000, "R4");
        drive(32'h00000000, 32'hC0000000, UP, 32'hC0000000, 5'b00000, "R4");
        // R5 / R6 infinities
        drive(32'h7F800000, 32'h7F800000, NE, 32'h7F800000, 5'b00000, "R5");
        drive(32'hFF800000, 32'hFF800000, RZ, 32'hFF800000, 5'b00000, "R5");
        drive(32'h7F800000, 32'hC0000000, NE, 32'h7F800000, 5'b00000, "R5");
        drive(32'h7F800000, 32'hFF800000, NE, 32'hFFC00000, 5'b10000, "R6");
        // R7 NaN selection and signalling detection
        drive(32'h7FC00001, 32'h3F800000, NE, 32'h7FC00001, 5'b00000, "R7");
        drive(32'h3F800000, 32'h7F800001, NE, 32'h7FC00001, 5'b10000, "R7");
        drive(32'h3F800000, 32'hFFC00002, NE, 32'hFFC00002, 5'b00000, "R7");
        drive(32'h7FA00000, 32'h7FC00000, NE, 32'h7FE00000, 5'b10000, "R7");
        drive(32'h7FC00000, 32'h7F800001, NE, 32'h7FC00000, 5'b10000, "R7");
        // R8 / R10 denormals
        drive(32'h3F800000, 32'h00000001, NE, 32'h3F800000, 5'b01000, "R8");
        drive(32'h3F800000, 32'h00000001, UP, 32'h3F800001, 5'b01001, "R8");
        drive(32'h00000001, 32'h00000000, NE, 32'h00000001, 5'b01010, "R10");
        drive(32'h00000001, 32'h00000001, NE, 32'h00000002, 5'b01010, "R10");
        drive(32'h00800000, 32'h80000001, NE, 32'h007FFFFF, 5'b01010, "R10");
        drive(32'h00400000, 32'h00400000, NE, 32'h00800000, 5'b01000, "R10");
        // R9 overflow in every mode and sign
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, NE, 32'h7F800000, 5'b00101, "R9");
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, RZ, 32'h7F7FFFFF, 5'b00100, "R9");
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, DN, 32'h7F7FFFFF, 5'b00100, "R9");
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, UP, 32'h7F800000, 5'b00101, "R9");
        drive(32'hFF7FFFFF, 32'hFF7FFFFF, DN, 32'hFF800000, 5'b00101, "R9");
        drive(32'hFF7FFFFF, 32'hFF7FFFFF, UP, 32'hFF7FFFFF, 5'b00100, "R9");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1 everything returned, nothing extra while idle
        checks++;
        if (sb_q.size() != 0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: pending %0d valid %b, expected 0 and 0", sb_q.size(), out_valid);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule